// File: doc/BRIEF.md
# Trace Instruction Address Filter

This block decides, for every retired instruction presented to it, whether that instruction belongs in the trace stream. It sees the instruction address, the exception level (0 to 3) and the security state. It combines three filters into one trace-enable flag. Address comparator pairs act as include ranges. Single address comparators drive a start/stop latch that has hysteresis. Each comparator carries an access word whose bits mask out matching at chosen exception levels.

Software programs the block through a one-cycle register write port. The port reaches the comparator values, their access words, the include mask, the start/stop control word and the view control word. The view control word holds the enabling-event bit and the start/stop status. The status is always visible on an output. Software can save it when trace is suspended and write it back to resume from the same state.

Top module: `trace_addr_filter`

## Requirements
- R1: After synchronous reset the start/stop status reads 0, the enabling event is off, every comparator value, access word and mask is zero, and trace_en is 0.
- R2: trace_en is 1 only when instr_valid is 1 and bit 0 of the view control word (select 4) is 1.
- R3: Comparators 2k (lower bound) and 2k+1 (upper bound) form range pair k. The pair is active when bit k of the include mask (select 2) is set. An active pair passes an address that lies within its bounds, both bounds included, compared as unsigned. When at least one pair is active, trace_en requires a hit in one of the active pairs.
- R4: When the include mask is zero, the address range places no restriction on trace_en.
- R5: A comparator matches only if its access word permits the current level. Word bit 12+el excludes non-secure level el, and word bit 8+el excludes secure level el. A range pair uses the access word of its even comparator.
- R6: In the start/stop control word (select 3), bit i marks comparator i as a start point and bit 16+i marks it as a stop point. An exact-address start match on a valid instruction sets the status from the next instruction on. The status is not changed for the matching instruction itself.
- R7: A stop match on a valid instruction clears the status from the next instruction on. When a start match and a stop match fall on the same instruction, the stop match wins.
- R8: Bit 9 of the view control word loads the status and ss_status shows it. When the start/stop control word is zero, the status does not gate trace_en.
- R9: A start or stop point may use any comparator index, odd ones included.
- R10: A write to the view control word in the same cycle as a start or stop match takes priority, so the written bit 9 becomes the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Target: 0 comparator value, 1 access word, 2 include mask, 3 start/stop control, 4 view control |
| cfg_idx | input | 3 | Comparator index for selects 0 and 1 |
| cfg_wdata | input | 64 | Write data |
| instr_valid | input | 1 | A retired instruction is presented |
| instr_addr | input | 64 | Instruction address |
| instr_el | input | 2 | Exception level |
| instr_secure | input | 1 | 1 for secure state |
| trace_en | output | 1 | Trace this instruction |
| ss_status | output | 1 | Current start/stop status |

## Verification
Two functions can fall in the same cycle. The first case is a start match together with a stop match. The bench provokes it by giving both comparators the same address with the status set, then checks that the status reads 0 afterwards. The second case is a view control write landing in the same cycle as a start match. The bench drives both together and expects the written status, not the one the match would give. The status is judged through ss_status and through trace_en on the following instruction.

// File: rtl/itf_pkg.sv
package itf_pkg;
    localparam int ADDR_W       = 64;
    localparam int VIEW_EVT_BIT = 0;
    localparam int VIEW_SS_BIT  = 9;
    localparam int SS_STOP_BASE = 16;
    localparam int ACC_NS_BASE  = 12;
    localparam int ACC_S_BASE   = 8;

    typedef enum logic [2:0] {
        SEL_CMP_VAL  = 3'd0,
        SEL_CMP_ACC  = 3'd1,
        SEL_INC_MASK = 3'd2,
        SEL_SS_CTL   = 3'd3,
        SEL_VIEW_CTL = 3'd4
    } cfg_sel_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [1:0]        el;
        logic              secure;
    } instr_t;

    function automatic logic level_allowed(input logic [15:0] acc, input logic [1:0] el,
                                           input logic secure);
        logic [3:0] excl;
        excl = secure ? acc[ACC_S_BASE +: 4] : acc[ACC_NS_BASE +: 4];
        return !excl[el];
    endfunction
endpackage

// File: rtl/itf_cfg_regs.sv
module itf_cfg_regs
    import itf_pkg::*;
#(
    parameter int NUM_PAIRS = 4,
    localparam int NUM_CMP  = 2 * NUM_PAIRS,
    localparam int IDX_W    = $clog2(NUM_CMP)
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             cfg_we,
    input  logic [2:0]                       cfg_sel,
    input  logic [IDX_W-1:0]                 cfg_idx,
    input  logic [ADDR_W-1:0]                cfg_wdata,
    output logic [NUM_CMP-1:0][ADDR_W-1:0]   cmp_val,
    output logic [NUM_CMP-1:0][15:0]         cmp_acc,
    output logic [NUM_PAIRS-1:0]             inc_mask,
    output logic [NUM_CMP-1:0]               ss_start,
    output logic [NUM_CMP-1:0]               ss_stop,
    output logic                             evt_en,
    output logic                             view_wr,
    output logic                             view_ss
);
    cfg_sel_e sel;
    assign sel     = cfg_sel_e'(cfg_sel);
    assign view_wr = cfg_we && (sel == SEL_VIEW_CTL);
    assign view_ss = cfg_wdata[VIEW_SS_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_val  <= '0;
            cmp_acc  <= '0;
            inc_mask <= '0;
            ss_start <= '0;
            ss_stop  <= '0;
            evt_en   <= 1'b0;
        end else if (cfg_we) begin
            case (sel)
                SEL_CMP_VAL:  cmp_val[cfg_idx] <= cfg_wdata;
                SEL_CMP_ACC:  cmp_acc[cfg_idx] <= cfg_wdata[15:0];
                SEL_INC_MASK: inc_mask <= cfg_wdata[NUM_PAIRS-1:0];
                SEL_SS_CTL: begin
                    ss_start <= cfg_wdata[NUM_CMP-1:0];
                    ss_stop  <= cfg_wdata[SS_STOP_BASE +: NUM_CMP];
                end
                SEL_VIEW_CTL: evt_en <= cfg_wdata[VIEW_EVT_BIT];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/itf_cmp_bank.sv
module itf_cmp_bank
    import itf_pkg::*;
#(
    parameter int NUM_PAIRS = 4,
    localparam int NUM_CMP  = 2 * NUM_PAIRS
) (
    input  instr_t                           instr,
    input  logic [NUM_CMP-1:0][ADDR_W-1:0]   cmp_val,
    input  logic [NUM_CMP-1:0][15:0]         cmp_acc,
    output logic [NUM_CMP-1:0]               single_hit,
    output logic [NUM_PAIRS-1:0]             range_hit
);
    for (genvar i = 0; i < NUM_CMP; i++) begin : g_single
        assign single_hit[i] = level_allowed(cmp_acc[i], instr.el, instr.secure)
                               && (instr.addr == cmp_val[i]);
    end

    for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_range
        assign range_hit[k] = level_allowed(cmp_acc[2*k], instr.el, instr.secure)
                              && (instr.addr >= cmp_val[2*k])
                              && (instr.addr <= cmp_val[2*k+1]);
    end
endmodule

// File: rtl/itf_ss_tracker.sv
module itf_ss_tracker (
    input  logic clk,
    input  logic rst,
    input  logic instr_valid,
    input  logic start_any,
    input  logic stop_any,
    input  logic view_wr,
    input  logic view_ss,
    output logic status
);
    always_ff @(posedge clk) begin
        if (rst)
            status <= 1'b0;
        else if (view_wr)
            status <= view_ss;
        else if (instr_valid && stop_any)
            status <= 1'b0;
        else if (instr_valid && start_any)
            status <= 1'b1;
    end
endmodule

// File: rtl/trace_addr_filter.sv
module trace_addr_filter
    import itf_pkg::*;
#(
    parameter int NUM_PAIRS = 4,
    localparam int NUM_CMP  = 2 * NUM_PAIRS,
    localparam int IDX_W    = $clog2(NUM_CMP)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [63:0]       cfg_wdata,
    input  logic              instr_valid,
    input  logic [63:0]       instr_addr,
    input  logic [1:0]        instr_el,
    input  logic              instr_secure,
    output logic              trace_en,
    output logic              ss_status
);
    logic [NUM_CMP-1:0][ADDR_W-1:0] cmp_val;
    logic [NUM_CMP-1:0][15:0]       cmp_acc;
    logic [NUM_PAIRS-1:0]           inc_mask;
    logic [NUM_CMP-1:0]             ss_start;
    logic [NUM_CMP-1:0]             ss_stop;
    logic                           evt_en;
    logic                           view_wr;
    logic                           view_ss;
    logic [NUM_CMP-1:0]             single_hit;
    logic [NUM_PAIRS-1:0]           range_hit;
    logic                           start_any;
    logic                           stop_any;
    logic                           ss_used;
    logic                           inc_ok;
    instr_t                         instr;

    assign instr = '{addr: instr_addr, el: instr_el, secure: instr_secure};

    itf_cfg_regs #(.NUM_PAIRS(NUM_PAIRS)) u_cfg (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .cmp_val(cmp_val), .cmp_acc(cmp_acc), .inc_mask(inc_mask),
        .ss_start(ss_start), .ss_stop(ss_stop), .evt_en(evt_en), .view_wr(view_wr),
        .view_ss(view_ss)
    );

    itf_cmp_bank #(.NUM_PAIRS(NUM_PAIRS)) u_bank (
        .instr(instr), .cmp_val(cmp_val), .cmp_acc(cmp_acc),
        .single_hit(single_hit), .range_hit(range_hit)
    );

    assign start_any = |(single_hit & ss_start);
    assign stop_any  = |(single_hit & ss_stop);
    assign ss_used   = |{ss_start, ss_stop};
    assign inc_ok    = (inc_mask == '0) || (|(range_hit & inc_mask));

    itf_ss_tracker u_ss (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .start_any(start_any),
        .stop_any(stop_any), .view_wr(view_wr), .view_ss(view_ss), .status(ss_status)
    );

    assign trace_en = instr_valid && evt_en && inc_ok && (!ss_used || ss_status);
endmodule

// File: rtl/trace_addr_filter_chk.sv
module trace_addr_filter_chk (
    input logic       clk,
    input logic       rst,
    input logic       cfg_we,
    input logic [2:0] cfg_sel,
    input logic       instr_valid,
    input logic       trace_en,
    input logic       ss_status,
    input logic       evt_en,
    input logic       inc_ok,
    input logic       ss_used,
    input logic       start_any,
    input logic       stop_any
);
    logic vw;
    assign vw = cfg_we && (cfg_sel == 3'd4);

    assert_reset_state_R1: assert property (@(posedge clk) $fell(rst) |-> (!ss_status && !trace_en));
    assert_event_gate_R2: assert property (@(posedge clk) disable iff (rst)
        trace_en |-> (evt_en && instr_valid));
    assert_include_gate_R3: assert property (@(posedge clk) disable iff (rst)
        trace_en |-> inc_ok);
    assert_start_sets_R6: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && start_any && !stop_any && !vw) |=> ss_status);
    assert_stop_wins_R7: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && stop_any && !vw) |=> !ss_status);
    assert_status_gate_R8: assert property (@(posedge clk) disable iff (rst)
        (trace_en && ss_used) |-> ss_status);
    assert_status_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!vw && !instr_valid) |=> $stable(ss_status));
endmodule

bind trace_addr_filter trace_addr_filter_chk u_chk (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .instr_valid(instr_valid),
    .trace_en(trace_en), .ss_status(ss_status), .evt_en(evt_en), .inc_ok(inc_ok),
    .ss_used(ss_used), .start_any(start_any), .stop_any(stop_any)
);

// File: tb/trace_addr_filter_tb_top.sv
module trace_addr_filter_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [2:0]  cfg_sel;
    logic [2:0]  cfg_idx;
    logic [63:0] cfg_wdata;
    logic        instr_valid;
    logic [63:0] instr_addr;
    logic [1:0]  instr_el;
    logic        instr_secure;
    logic        trace_en;
    logic        ss_status;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    trace_addr_filter dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .instr_valid(instr_valid), .instr_addr(instr_addr),
        .instr_el(instr_el), .instr_secure(instr_secure), .trace_en(trace_en),
        .ss_status(ss_status)
    );

    // {mask[7:0], addr[63:0], el[1:0], secure, expected trace_en}
    localparam int NV = 9;
    localparam logic [75:0] VEC [NV] = '{
        {8'h01, 64'h1000,  2'd0, 1'b0, 1'b1},  // R3 lower bound
        {8'h01, 64'h1FFF,  2'd2, 1'b0, 1'b1},  // R3 upper bound
        {8'h01, 64'h0FFF,  2'd0, 1'b0, 1'b0},  // R3 below
        {8'h01, 64'h2000,  2'd0, 1'b0, 1'b0},  // R3 above
        {8'h01, 64'h8100,  2'd0, 1'b0, 1'b0},  // R3 pair 1 not active
        {8'h03, 64'h8100,  2'd0, 1'b0, 1'b1},  // R3 pair 1 active
        {8'h03, 64'h8100,  2'd1, 1'b0, 1'b0},  // R5 NS EL1 excluded
        {8'h03, 64'h8100,  2'd1, 1'b1, 1'b1},  // R5 secure EL1 allowed
        {8'h00, 64'h12345, 2'd1, 1'b0, 1'b1}   // R4 empty mask
    };

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [2:0] sel, input logic [2:0] idx, input logic [63:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_idx = idx; cfg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Presents one instruction, optionally with a view control write in the same cycle.
    task automatic issue(input logic [63:0] a, input logic [1:0] el, input logic sec,
                         input bit with_view, input logic [63:0] view, input string req,
                         input logic exp_trace);
        @(negedge clk);
        instr_valid = 1'b1; instr_addr = a; instr_el = el; instr_secure = sec;
        if (with_view) begin
            cfg_we = 1'b1; cfg_sel = 3'd4; cfg_idx = 3'd0; cfg_wdata = view;
        end
        #1 check(req, trace_en, exp_trace);
        @(posedge clk);
        @(negedge clk);
        instr_valid = 1'b0; cfg_we = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cfg_we = 1'b0; cfg_sel = '0; cfg_idx = '0; cfg_wdata = '0;
        instr_valid = 1'b0; instr_addr = '0; instr_el = '0; instr_secure = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        check("R1 status", ss_status, 1'b0);
        issue(64'h1000, 2'd0, 1'b0, 0, 0, "R1 trace after reset", 1'b0);

        cfg_write(3'd0, 3'd0, 64'h1000);
        cfg_write(3'd0, 3'd1, 64'h1FFF);
        cfg_write(3'd0, 3'd2, 64'h8000);
        cfg_write(3'd0, 3'd3, 64'h8FFF);
        cfg_write(3'd1, 3'd2, 64'h2000);
        cfg_write(3'd1, 3'd3, 64'h2000);
        cfg_write(3'd4, 3'd0, 64'h1);

        for (int i = 0; i < NV; i++) begin
            cfg_write(3'd2, 3'd0, {56'h0, VEC[i][75:68]});
            issue(VEC[i][67:4], VEC[i][3:2], VEC[i][1], 0, 0, "R3/R4/R5 vector", VEC[i][0]);
        end

        // R2: enabling event off blocks everything
        cfg_write(3'd4, 3'd0, 64'h0);
        issue(64'h1000, 2'd0, 1'b0, 0, 0, "R2 event off", 1'b0);
        cfg_write(3'd4, 3'd0, 64'h1);

        // start at comparator 2, stop at odd comparator 3
        cfg_write(3'd2, 3'd0, 64'h0);
        cfg_write(3'd0, 3'd2, 64'h4000);
        cfg_write(3'd0, 3'd3, 64'h5000);
        cfg_write(3'd3, 3'd0, 64'h0008_0004);

        issue(64'h4000, 2'd1, 1'b0, 0, 0, "R5 excluded start", 1'b0);
        check("R5 no start at excluded level", ss_status, 1'b0);
        issue(64'h4000, 2'd0, 1'b0, 0, 0, "R6 start instr not traced", 1'b0);
        check("R6 status set", ss_status, 1'b1);
        issue(64'h4004, 2'd0, 1'b0, 0, 0, "R6 traced after start", 1'b1);
        issue(64'h5000, 2'd0, 1'b0, 0, 0, "R9 stop instr still traced", 1'b1);
        check("R9 odd stop clears", ss_status, 1'b0);
        issue(64'h5004, 2'd0, 1'b0, 0, 0, "R7 not traced after stop", 1'b0);

        // R10: view write beats a start match
        issue(64'h4000, 2'd0, 1'b0, 1, 64'h1, "R10 same-cycle write", 1'b0);
        check("R10 write wins", ss_status, 1'b0);

        // R8: restore status by write
        cfg_write(3'd4, 3'd0, 64'h201);
        check("R8 status restored", ss_status, 1'b1);
        issue(64'h4100, 2'd0, 1'b0, 0, 0, "R8 traced after restore", 1'b1);

        // R7: start and stop on the same instruction
        cfg_write(3'd0, 3'd3, 64'h4000);
        issue(64'h4000, 2'd0, 1'b0, 0, 0, "R7 both match, status was 1", 1'b1);
        check("R7 stop wins from 1", ss_status, 1'b0);
        issue(64'h4000, 2'd0, 1'b0, 0, 0, "R7 both match, status was 0", 1'b0);
        check("R7 stop wins from 0", ss_status, 1'b0);

        // R8: start/stop unused -> status ignored
        cfg_write(3'd3, 3'd0, 64'h0);
        issue(64'h7000, 2'd0, 1'b0, 0, 0, "R8 status ignored", 1'b1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule